// File: doc/BRIEF.md
# Level-Sensitive Scan Latch Chain

This block is a chain of N storage cells for manufacturing test. Each cell holds two storage elements, a first-rank latch and a second-rank latch. There is no mode select signal. Each storage element responds only to the level strobes that belong to it, so the active strobe decides whether a capture is functional or a scan shift.

In functional operation the first rank captures its parallel data on system strobe one. The second rank captures on system strobe two, either from its own parallel data or from the first rank. In scan operation, shift strobe A loads each first rank from the previous cell's second rank, and the first cell loads from the serial input. Shift strobe B then copies each first rank into its second rank. One A pulse followed by one B pulse moves the whole chain by one position.

All strobes are level signals sampled on the fabric clock `clk`. Each storage element is a register that follows its selected source on every clock edge while its strobe is high, and it holds otherwise. A guard raises an error flag for any illegal strobe combination.

Top module: `lvl_scan_chain`

## Requirements
- R1: A synchronous reset, held high across a rising edge of `clk`, clears every bit of `q1` and `q2`, clears `scan_out` and clears `clk_err`.
- R2: On an edge where `cap1` is high and `shift_a` and `shift_b` are low, every first-rank bit `q1[i]` takes `d1[i]` after that edge.
- R3: With the default `L2_SYSTEM = 1`, on an edge where `cap2` is high and `shift_b` and `shift_a` are low, every second-rank bit `q2[i]` takes `d2[i]` after that edge, independently of `q1`.
- R4: On an edge where all four strobes are low, `q1` and `q2` keep their values whatever `d1`, `d2` and `scan_in` do.
- R5: On an edge where `shift_a` is high and `cap1` and `shift_b` are low, `q1[0]` takes `scan_in` and `q1[i]` takes the old `q2[i-1]`. On an edge where `shift_b` is high and `cap2` and `shift_a` are low, `q2[i]` takes the old `q1[i]`.
- R6: N A-then-B pulse pairs load N serial bits. The first bit shifted in ends in cell N-1. `scan_out` is `q2[N-1]`, so the first bit shifted out is the content of the last cell.
- R7: On an edge where `shift_a` and `shift_b` are both high, every latch holds its value and `clk_err` is 1 after that edge.
- R8: On an edge where `cap1` and `shift_a` are both high, the first rank holds. On an edge where `cap2` and `shift_b` are both high, the second rank holds. In both cases `clk_err` is 1 after that edge.
- R9: `clk_err` is not sticky. It is 0 after any edge without a strobe conflict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock on which every strobe is sampled |
| rst | input | 1 | Synchronous active-high reset |
| cap1 | input | 1 | System strobe for the first rank |
| cap2 | input | 1 | System strobe for the second rank |
| shift_a | input | 1 | Scan strobe A, loads the first rank from the serial path |
| shift_b | input | 1 | Scan strobe B, copies first rank into second rank |
| scan_in | input | 1 | Serial input to cell 0 |
| d1 | input | N | Functional data for the first rank of each cell |
| d2 | input | N | Functional data for the second rank of each cell |
| q1 | output | N | First-rank contents |
| q2 | output | N | Second-rank contents |
| scan_out | output | 1 | Serial output, second rank of cell N-1 |
| clk_err | output | 1 | Strobe conflict seen on the previous edge |

## Verification
Every storage bit is a port, so a wrong latch value appears on `q1` or `q2` one edge after the faulty capture. A misrouted link in the serial path appears on `scan_out` only after that bit has been shifted to the end of the chain, which takes up to N pulse pairs. For that reason the bench unloads a full pattern after each capture. A missed hold during a strobe conflict shows one edge later, as a changed `q1`/`q2` bit next to a raised `clk_err`.

// File: rtl/lsc_pkg.sv
package lsc_pkg;

  // Sampled levels of the four strobes at one fabric clock edge.
  typedef struct packed {
    logic sys1;
    logic sys2;
    logic sa;
    logic sb;
  } lsc_strobes_t;

  // Any combination that must never be applied.
  function automatic logic strobe_conflict(input lsc_strobes_t s);
    return (s.sa & s.sb) | (s.sys1 & s.sa) | (s.sys2 & s.sb);
  endfunction

endpackage

// File: rtl/lsc_latch.sv
// One level-sensitive storage element, modelled as a register that follows
// its selected source on each edge while exactly one of its strobes is high.
module lsc_latch (
  input  logic clk,
  input  logic rst,
  input  logic sys_en,
  input  logic sys_d,
  input  logic scan_en,
  input  logic scan_d,
  input  logic freeze,
  output logic q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= 1'b0;
    end else if (!freeze) begin
      if (sys_en && !scan_en) begin
        q <= sys_d;
      end else if (scan_en && !sys_en) begin
        q <= scan_d;
      end
    end
  end

endmodule

// File: rtl/lsc_cell.sv
// A pair of storage elements: first rank and second rank.
module lsc_cell #(
  parameter bit L2_SYSTEM = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  lsc_pkg::lsc_strobes_t stb,
  input  logic freeze,
  input  logic d1,
  input  logic d2,
  input  logic scan_d,
  output logic q1,
  output logic q2
);

  logic l2_sys_d;

  generate
    if (L2_SYSTEM) begin : g_l2_own
      assign l2_sys_d = d2;
    end else begin : g_l2_slave
      assign l2_sys_d = q1;
    end
  endgenerate

  lsc_latch u_l1 (
    .clk     (clk),
    .rst     (rst),
    .sys_en  (stb.sys1),
    .sys_d   (d1),
    .scan_en (stb.sa),
    .scan_d  (scan_d),
    .freeze  (freeze),
    .q       (q1)
  );

  lsc_latch u_l2 (
    .clk     (clk),
    .rst     (rst),
    .sys_en  (stb.sys2),
    .sys_d   (l2_sys_d),
    .scan_en (stb.sb),
    .scan_d  (q1),
    .freeze  (freeze),
    .q       (q2)
  );

endmodule

// File: rtl/lsc_clk_guard.sv
// Detects illegal strobe combinations; registers a per-edge error flag.
module lsc_clk_guard (
  input  logic clk,
  input  logic rst,
  input  lsc_pkg::lsc_strobes_t stb,
  output logic overlap,
  output logic err
);

  assign overlap = stb.sa & stb.sb;

  always_ff @(posedge clk) begin
    if (rst) begin
      err <= 1'b0;
    end else begin
      err <= lsc_pkg::strobe_conflict(stb);
    end
  end

endmodule

// File: rtl/lvl_scan_chain.sv
module lvl_scan_chain #(
  parameter int N         = 8,
  parameter bit L2_SYSTEM = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cap1,
  input  logic         cap2,
  input  logic         shift_a,
  input  logic         shift_b,
  input  logic         scan_in,
  input  logic [N-1:0] d1,
  input  logic [N-1:0] d2,
  output logic [N-1:0] q1,
  output logic [N-1:0] q2,
  output logic         scan_out,
  output logic         clk_err
);

  localparam int LAST = N - 1;

  lsc_pkg::lsc_strobes_t stb;
  logic                  overlap;
  logic [N-1:0]          link;

  assign stb = '{sys1: cap1, sys2: cap2, sa: shift_a, sb: shift_b};

  lsc_clk_guard u_guard (
    .clk     (clk),
    .rst     (rst),
    .stb     (stb),
    .overlap (overlap),
    .err     (clk_err)
  );

  generate
    for (genvar i = 0; i < N; i++) begin : g_cell
      if (i == 0) begin : g_head
        assign link[i] = scan_in;
      end else begin : g_body
        assign link[i] = q2[i-1];
      end

      lsc_cell #(.L2_SYSTEM(L2_SYSTEM)) u_cell (
        .clk    (clk),
        .rst    (rst),
        .stb    (stb),
        .freeze (overlap),
        .d1     (d1[i]),
        .d2     (d2[i]),
        .scan_d (link[i]),
        .q1     (q1[i]),
        .q2     (q2[i])
      );
    end
  endgenerate

  assign scan_out = q2[LAST];

endmodule

// File: rtl/lvl_scan_chain_chk.sv
module lvl_scan_chain_chk #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         cap1,
  input logic         cap2,
  input logic         shift_a,
  input logic         shift_b,
  input logic         scan_in,
  input logic [N-1:0] d1,
  input logic [N-1:0] q1,
  input logic [N-1:0] q2,
  input logic         clk_err
);

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (q1 == '0 && q2 == '0 && !clk_err));

  assert_sys1_capture_R2: assert property (@(posedge clk) disable iff (rst)
    (cap1 && !shift_a && !shift_b) |=> (q1 == $past(d1)));

  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!cap1 && !cap2 && !shift_a && !shift_b) |=> ($stable(q1) && $stable(q2)));

  assert_scan_head_R5: assert property (@(posedge clk) disable iff (rst)
    (shift_a && !cap1 && !shift_b) |=> (q1[0] == $past(scan_in)));

  assert_b_copy_R5: assert property (@(posedge clk) disable iff (rst)
    (shift_b && !cap2 && !shift_a) |=> (q2 == $past(q1)));

  assert_no_ab_overlap_R7: assert property (@(posedge clk) disable iff (rst)
    (shift_a && shift_b) |=> (clk_err && $stable(q1) && $stable(q2)));

  assert_l1_clash_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (cap1 && shift_a) |=> (clk_err && $stable(q1)));

  assert_l2_clash_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (cap2 && shift_b) |=> (clk_err && $stable(q2)));

  assert_err_clears_R9: assert property (@(posedge clk) disable iff (rst)
    (!(shift_a && shift_b) && !(cap1 && shift_a) && !(cap2 && shift_b))
      |=> !clk_err);

endmodule

bind lvl_scan_chain lvl_scan_chain_chk #(.N(N)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .cap1    (cap1),
  .cap2    (cap2),
  .shift_a (shift_a),
  .shift_b (shift_b),
  .scan_in (scan_in),
  .d1      (d1),
  .q1      (q1),
  .q2      (q2),
  .clk_err (clk_err)
);

// File: tb/lvl_scan_chain_test.sv
module lvl_scan_chain_test;

  localparam int CLK_PERIOD = 10;
  localparam int N          = 8;
  localparam int ROWS       = 10;

  typedef struct packed {
    logic         c1;
    logic         c2;
    logic         a;
    logic         b;
    logic         sin;
    logic [N-1:0] d1;
    logic [N-1:0] d2;
    logic         err;
  } vec_t;

  // strobes c1 c2 a b, scan_in, d1, d2, expected clk_err
  localparam vec_t TBL [ROWS] = '{
    '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'hA5, 8'h3C, 1'b0},  // R2 first-rank capture
    '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'hFF, 8'h3C, 1'b0},  // R3 second-rank capture
    '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 8'h00, 1'b0},  // R4 idle hold
    '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 8'h00, 8'h00, 1'b0},  // R5 A shift
    '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 8'h00, 1'b0},  // R5 B copy
    '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'h11, 8'h22, 1'b1},  // R7 overlap
    '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 1'b0},  // R9 flag clears
    '{1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h0F, 8'h00, 1'b1},  // R8 first-rank clash
    '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00, 8'hF0, 1'b1},  // R8 second-rank clash
    '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h5A, 8'hC3, 1'b0}   // R2 R3 both system strobes
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cap1 = 1'b0, cap2 = 1'b0, shift_a = 1'b0, shift_b = 1'b0;
  logic         scan_in = 1'b0;
  logic [N-1:0] d1 = '0, d2 = '0;
  logic [N-1:0] q1, q2;
  logic         scan_out, clk_err;

  logic [N-1:0] m1 = '0, m2 = '0;
  logic         merr = 1'b0;
  int           n_run = 0, n_fail = 0;
  bit           done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  lvl_scan_chain #(.N(N)) uut (
    .clk      (clk),
    .rst      (rst),
    .cap1     (cap1),
    .cap2     (cap2),
    .shift_a  (shift_a),
    .shift_b  (shift_b),
    .scan_in  (scan_in),
    .d1       (d1),
    .d2       (d2),
    .q1       (q1),
    .q2       (q2),
    .scan_out (scan_out),
    .clk_err  (clk_err)
  );

  task automatic check(input bit ok, input string req, input logic [N-1:0] act,
                       input logic [N-1:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Apply one edge of stimulus (called at a falling edge), update the model,
  // and return at the next falling edge with the outputs settled.
  task automatic tick(input logic c1, c2, a, b, sin,
                      input logic [N-1:0] v1, v2);
    logic [N-1:0] n1, n2;
    cap1 = c1; cap2 = c2; shift_a = a; shift_b = b; scan_in = sin;
    d1 = v1; d2 = v2;
    n1 = m1; n2 = m2;
    if (rst) begin
      n1 = '0; n2 = '0; merr = 1'b0;
    end else begin
      if (!(a && b) && !(c1 && a)) begin
        if (c1) n1 = v1;
        else if (a) n1 = {m2[N-2:0], sin};
      end
      if (!(a && b) && !(c2 && b)) begin
        if (c2) n2 = v2;
        else if (b) n2 = m1;
      end
      merr = (a && b) || (c1 && a) || (c2 && b);
    end
    @(negedge clk);
    m1 = n1; m2 = n2;
  endtask

  task automatic check_model(input string req);
    check(q1 == m1, {req, " q1"}, q1, m1);
    check(q2 == m2, {req, " q2"}, q2, m2);
    check(clk_err == merr, {req, " clk_err"}, N'(clk_err), N'(merr));
  endtask

  task automatic shift_pair(input logic sin);
    tick(1'b0, 1'b0, 1'b1, 1'b0, sin, '0, '0);
    tick(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, '0, '0);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] pat, got;
    @(negedge clk);
    rst = 1'b1;
    tick(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'hFF, 8'hFF);
    tick(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, '0, '0);
    // R1 reset state
    check(q1 == '0 && q2 == '0, "R1 reset q", q1 | q2, '0);
    check(!scan_out && !clk_err, "R1 reset flags", N'({scan_out, clk_err}), '0);
    rst = 1'b0;

    for (int r = 0; r < ROWS; r++) begin
      tick(TBL[r].c1, TBL[r].c2, TBL[r].a, TBL[r].b, TBL[r].sin, TBL[r].d1, TBL[r].d2);
      check_model($sformatf("table row %0d", r));
      check(clk_err == TBL[r].err, $sformatf("table row %0d err", r),
            N'(clk_err), N'(TBL[r].err));
    end

    // R6 scan in a pattern, MSB first: it must end up in cell N-1
    pat = 8'hB4;
    for (int k = N - 1; k >= 0; k--) shift_pair(pat[k]);
    check(q2 == pat, "R6 scan-in load", q2, pat);
    check(scan_out == pat[N-1], "R6 scan_out is last cell", N'(scan_out), N'(pat[N-1]));
    check_model("R5 after shift");

    // R4 data toggles with idle strobes are ignored
    tick(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'hFF, 8'h00);
    check(q2 == pat, "R4 hold under idle", q2, pat);

    // R2 R3 system capture, then scan result out and compare
    tick(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h69, 8'h00);
    check(q1 == 8'h69, "R2 capture d1", q1, 8'h69);
    tick(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'hD2);
    check(q2 == 8'hD2, "R3 capture d2", q2, 8'hD2);
    check(q1 == 8'h69, "R3 first rank untouched", q1, 8'h69);
    got = '0;
    for (int k = N - 1; k >= 0; k--) begin
      got[k] = scan_out;
      shift_pair(1'b0);
    end
    check(got == 8'hD2, "R6 scan-out order", got, 8'hD2);

    // R7 overlap holds everything, R9 flag clears
    tick(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8'hFF, 8'hFF);
    check_model("R7 overlap");
    tick(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, '0, '0);
    check(!clk_err, "R9 clear", N'(clk_err), '0);

    // R1 mid-run reset
    tick(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'hFF, 8'hFF);
    rst = 1'b1;
    tick(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, '0, '0);
    rst = 1'b0;
    check(q1 == '0 && q2 == '0, "R1 mid-run reset", q1 | q2, '0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule